// File: doc/BRIEF.md
# Sector Usage History Predictor

This block predicts which words of a cache block will be needed when the block is fetched again. It keeps a history table of word masks, one bit per word of a cache block. Each mask records which words were used during an earlier stay of some block in the cache. When a request misses the block entirely, or misses some of its words, the enclosing cache presents the instruction address, the word offset and the demanded word bits. The block hashes the first two into a table index and returns the demanded bits merged with the stored mask. The merged mask is what the cache forwards downstream.

The block also keeps per-line training state in small arrays addressed by a line identifier that the cache supplies. When a line is allocated, the cache hands over the index that was used for its lookup, and the line's used-word mask starts empty. Every later load or store to the line marks its word in that mask. When the line is evicted, its mask replaces the history entry at the line's saved index. Cache data storage is not part of this block.

Top module: `sector_history_predictor`

## Requirements
- R1: After reset every history entry is zero, so a lookup returns only the demanded word bits. While `miss_valid` is low, `req_sectors` is zero.
- R2: The lookup index `req_index` is `miss_pc[10:2]` XOR the 3-bit `miss_word` zero-extended to 9 bits. This holds at the default 512 entries with a 4-byte instruction alignment.
- R3: While `miss_valid` is high, `req_sectors` equals `miss_demand` ORed with the history entry at `req_index`. It is a combinational function of the current inputs and the table state.
- R4: `alloc_valid` stores `alloc_index` as the saved index of line `alloc_line` and clears that line's used-word mask.
- R5: `touch_valid` sets bit `touch_word` (bit n stands for word n of the block) in the used-word mask of line `touch_line`.
- R6: `evict_valid` overwrites the history entry at line `evict_line`'s saved index with that line's used-word mask. The new value replaces the old one and is not ORed with it.
- R7: If an eviction and a lookup hit the same index in the same cycle, the lookup already returns the mask being written.
- R8: If an allocation and a touch name the same line in the same cycle, the allocation wins and the mask is left at zero.
- R9: An eviction changes only the entry at its own index; lookups at other indices are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the table and the line state |
| miss_valid | input | 1 | A miss or sector miss is being looked up |
| miss_pc | input | 32 | Instruction address of the missing access |
| miss_word | input | 3 | Word offset of the missing access |
| miss_demand | input | 8 | Word bits the access itself demands |
| req_sectors | output | 8 | Word bits to request downstream |
| req_index | output | 9 | History index of this lookup, kept by the cache for allocation |
| alloc_valid | input | 1 | A line is being allocated |
| alloc_line | input | 4 | Line being allocated |
| alloc_index | input | 9 | History index to save for the line |
| touch_valid | input | 1 | A load or store touched a resident line |
| touch_line | input | 4 | Line touched |
| touch_word | input | 3 | Word touched |
| evict_valid | input | 1 | A line is being evicted |
| evict_line | input | 4 | Line evicted |

## Verification
Cold lookups run with instruction addresses whose index bits are all zero, all one, or mixed, and with every word offset at an extreme or in the middle. A wrong bit slice or a wrong hash shows up in `req_index`, and a prediction that is not empty shows up as extra bits. A train-then-lookup pattern with several words touched separates a stored mask from the demanded word alone. Retraining the same index with fewer words separates overwrite from accumulate, and a lookup at a different index after training exposes writes that leak into other entries. Two same-cycle collisions complete the set. An eviction that coincides with a lookup at the same index shows whether the bypass is present, and an allocation that coincides with a touch of the same line shows which of the two wins.

// File: rtl/sector_history_predictor.sv
module sector_history_predictor #(
  parameter int PC_W    = 32,
  parameter int WORDS   = 8,
  parameter int ENTRIES = 512,
  parameter int LINES   = 16,
  parameter int PC_LSB  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  input  logic [PC_W-1:0]            miss_pc,
  input  logic [$clog2(WORDS)-1:0]   miss_word,
  input  logic [WORDS-1:0]           miss_demand,
  output logic [WORDS-1:0]           req_sectors,
  output logic [$clog2(ENTRIES)-1:0] req_index,
  input  logic                       alloc_valid,
  input  logic [$clog2(LINES)-1:0]   alloc_line,
  input  logic [$clog2(ENTRIES)-1:0] alloc_index,
  input  logic                       touch_valid,
  input  logic [$clog2(LINES)-1:0]   touch_line,
  input  logic [$clog2(WORDS)-1:0]   touch_word,
  input  logic                       evict_valid,
  input  logic [$clog2(LINES)-1:0]   evict_line
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WORD_W = $clog2(WORDS);

  logic [WORDS-1:0] hist      [ENTRIES];
  logic [IDX_W-1:0] line_idx  [LINES];
  logic [WORDS-1:0] line_used [LINES];

  logic [IDX_W-1:0] ev_idx;
  logic [WORDS-1:0] ev_mask;
  logic [WORDS-1:0] pred;
  logic             bypass;

  assign ev_idx    = line_idx[evict_line];
  assign ev_mask   = line_used[evict_line];
  assign req_index = miss_pc[PC_LSB +: IDX_W] ^ IDX_W'(miss_word);
  assign bypass    = evict_valid && (ev_idx == req_index);
  assign pred      = bypass ? ev_mask : hist[req_index];
  assign req_sectors = miss_valid ? (miss_demand | pred) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) hist[i] <= '0;
    end else if (evict_valid) begin
      hist[ev_idx] <= ev_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        line_idx[i]  <= '0;
        line_used[i] <= '0;
      end
    end else begin
      if (touch_valid && !(alloc_valid && alloc_line == touch_line))
        line_used[touch_line] <= line_used[touch_line] | (WORDS'(1) << touch_word);
      if (alloc_valid) begin
        line_idx[alloc_line]  <= alloc_index;
        line_used[alloc_line] <= '0;
      end
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_valid |-> req_sectors == '0);

  // R3
  demand_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (req_sectors & miss_demand) == miss_demand);

  // R4
  alloc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> line_used[$past(alloc_line)] == '0);

  // R5
  touch_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_valid && !(alloc_valid && alloc_line == touch_line)
      |=> line_used[$past(touch_line)][$past(touch_word)]);

  // R6
  evict_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evict_valid) && miss_valid && !evict_valid && req_index == $past(ev_idx)
      |-> req_sectors == (miss_demand | $past(ev_mask)));

  logic unused_w;
  assign unused_w = ^{WORD_W'(0)};
endmodule

// File: tb/sector_history_predictor_test.sv
module sector_history_predictor_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        miss_valid = 0;
  logic [31:0] miss_pc = 0;
  logic [2:0]  miss_word = 0;
  logic [7:0]  miss_demand = 0;
  logic [7:0]  req_sectors;
  logic [8:0]  req_index;
  logic        alloc_valid = 0;
  logic [3:0]  alloc_line = 0;
  logic [8:0]  alloc_index = 0;
  logic        touch_valid = 0;
  logic [3:0]  touch_line = 0;
  logic [2:0]  touch_word = 0;
  logic        evict_valid = 0;
  logic [3:0]  evict_line = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sector_history_predictor uut (.*);

  // {pc, word, demand, expected index, expected sectors}
  localparam logic [59:0] VEC [5] = '{
    {32'h0000_0000, 3'd0, 8'h01, 9'h000, 8'h01},
    {32'h0000_0010, 3'd3, 8'h08, 9'h007, 8'h08},
    {32'h0000_07FC, 3'd5, 8'h20, 9'h1FA, 8'h20},
    {32'hFFFF_F804, 3'd1, 8'h02, 9'h000, 8'h02},
    {32'h1234_5678, 3'd7, 8'h80, 9'h199, 8'h80}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] pc, logic [2:0] w, logic [7:0] d);
    miss_valid = 1; miss_pc = pc; miss_word = w; miss_demand = d;
  endtask

  task automatic step;
    @(negedge clk);
    miss_valid = 0; alloc_valid = 0; touch_valid = 0; evict_valid = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check("R1 idle output", req_sectors, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      lookup(VEC[i][59:28], VEC[i][27:25], VEC[i][24:17]);
      #1;
      check("R2 index", req_index, VEC[i][16:8]);
      check("R1 cold prediction", req_sectors, VEC[i][7:0]);
      step();
    end

    // train line 2 at index 7 with words 1,3,6
    alloc_valid = 1; alloc_line = 2; alloc_index = 9'h007; step();
    touch_valid = 1; touch_line = 2; touch_word = 1; step();
    touch_valid = 1; touch_line = 2; touch_word = 3; step();
    touch_valid = 1; touch_line = 2; touch_word = 6; step();
    evict_valid = 1; evict_line = 2; step();
    lookup(32'h10, 3'd3, 8'h08); #1;
    check("R5 R6 R3 trained mask", req_sectors, 8'h4A);
    step();
    lookup(32'h0, 3'd0, 8'h01); #1;
    check("R9 other entry untouched", req_sectors, 8'h01);
    step();

    // retrain index 7 with word 0 only
    alloc_valid = 1; alloc_line = 2; alloc_index = 9'h007; step();
    touch_valid = 1; touch_line = 2; touch_word = 0; step();
    evict_valid = 1; evict_line = 2; step();
    lookup(32'h10, 3'd3, 8'h08); #1;
    check("R6 R4 overwrite not accumulate", req_sectors, 8'h09);
    step();

    // same-cycle eviction and lookup at index 0x1FA
    alloc_valid = 1; alloc_line = 5; alloc_index = 9'h1FA; step();
    touch_valid = 1; touch_line = 5; touch_word = 4; step();
    evict_valid = 1; evict_line = 5;
    lookup(32'h7FC, 3'd5, 8'h20); #1;
    check("R7 bypass", req_sectors, 8'h30);
    step();
    lookup(32'h7FC, 3'd5, 8'h20); #1;
    check("R6 stored after bypass", req_sectors, 8'h30);
    step();

    // allocation and touch of line 3 in one cycle
    alloc_valid = 1; alloc_line = 3; alloc_index = 9'h0AA;
    touch_valid = 1; touch_line = 3; touch_word = 2; step();
    evict_valid = 1; evict_line = 3; step();
    lookup(32'h2A8, 3'd0, 8'h01); #1;
    check("R8 allocation wins", req_sectors, 8'h01);
    check("R2 index 0AA", req_index, 9'h0AA);
    step();
    #1 check("R1 idle after lookups", req_sectors, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule